// File: doc/BRIEF.md
# Bus Cycle Drive Controller

This block sits between the execution core of an 8-bit, 16-bit-address processor and its external pins. The core updates its bus request (address, write data, write flag, read-modify-write flag, opcode-fetch flag) on the falling edge of the input clock. The block latches that request into a bus-cycle register on the same edge. It drives the external address, data and read/write lines from that register, along with one output-enable for each group. It also reports the read-modify-write and opcode-fetch status. It produces two non-overlapping clock phases derived from the input clock.

A wait input can hold the current bus cycle and stall the core. Three strap inputs select how the wait behaves and how the bus is driven. One strap lets the wait input stall writes or stops it from doing so. One strap drives write data for the whole clock or only for the phase-2 half. One strap samples the wait input on the rising clock edge or uses it directly. A bus-float input releases the address, data and read/write drivers. It does not stop the core, and it does not alter the stall.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While `aec_i` is low, `addr_oe_o`, `rw_oe_o` and `data_oe_o` are all 0. `aec_i` has no effect on `core_stall_o`. While `aec_i` is high, `addr_oe_o` and `rw_oe_o` are 1.
- R2: `addr_o`, `data_o` and `rw_n_o` show the latched bus cycle. `rw_n_o` is 1 for a read and 0 for a write. The latched cycle takes the core request at each falling edge of `clk_i` on which `core_stall_o` is 0.
- R3: On a read cycle, `core_stall_o` equals the inverse of the conditioned wait level. The wait level is active when low.
- R4: On a write cycle with `strap_wr_nopause_i` high, `core_stall_o` is 0. With the strap low, a write cycle stalls exactly as a read does.
- R5: With `strap_half_wr_i` low, `data_oe_o` is 1 for the whole of a write cycle while `aec_i` is high. It is 0 on read cycles.
- R6: With `strap_half_wr_i` high, `data_oe_o` is 1 on a write cycle only while `clk_i` is low, which is phase 2 high, and `aec_i` is high.
- R7: `ml_n_o` is 0 exactly when the latched cycle carries the read-modify-write flag. `sync_o` is 1 exactly when the latched cycle carries the opcode-fetch flag.
- R8: `phi2_o` is the inverse of `clk_i` and `phi1_o` equals `clk_i`.
- R9: With `strap_sync_rdy_i` high, the conditioned wait level is `rdy_i` as sampled at the most recent rising edge of `clk_i`. With the strap low, it is `rdy_i` itself.
- R10: While `rst_ni` is low, the latched cycle is a read of address 0 with data 0 and with both flags clear. The rising-edge wait sample is forced to 1 (ready).
- R11: While `core_stall_o` is high across a falling edge, the latched cycle keeps its value, whatever the core request is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; the bus cycle advances on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_addr_i | input | ADDR_W | Address requested by the core |
| core_wdata_i | input | DATA_W | Write data from the core |
| core_we_i | input | 1 | Core requests a write cycle |
| core_rmw_i | input | 1 | Request belongs to a read-modify-write sequence |
| core_fetch_i | input | 1 | Request is an opcode fetch |
| rdy_i | input | 1 | External wait request, low = wait |
| aec_i | input | 1 | Bus drive allowed; low floats the bus |
| strap_wr_nopause_i | input | 1 | High: wait never stalls writes |
| strap_half_wr_i | input | 1 | High: write data driven during phase 2 only |
| strap_sync_rdy_i | input | 1 | High: wait sampled on the rising clock edge |
| addr_o | output | ADDR_W | External address |
| addr_oe_o | output | 1 | Address drive enable |
| data_o | output | DATA_W | External write data |
| data_oe_o | output | 1 | Data drive enable |
| rw_n_o | output | 1 | 1 = read, 0 = write |
| rw_oe_o | output | 1 | Read/write line drive enable |
| core_stall_o | output | 1 | Holds the core in its current cycle |
| ml_n_o | output | 1 | Low during read-modify-write cycles |
| sync_o | output | 1 | High during opcode fetch cycles |
| phi1_o | output | 1 | Phase-1 clock |
| phi2_o | output | 1 | Phase-2 clock |

## Verification
A bus float and a wait stall can fall in the same cycle. When they do, the stall must still freeze the latched cycle, while every drive enable reads 0. The bench draws a random `aec_i` and a random `rdy_i` on every cycle, so the two overlap often, and the straps change every 40 cycles. A behavioural model predicts the latched cycle from the stall it computed before each falling edge. The bench compares the enables, the stall and the held address in both clock halves. A write that must not stall under the no-pause strap, together with a half-phase data enable, is judged in the same way.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef struct packed {
    logic we;
    logic rmw;
    logic fetch;
  } cyc_flags_t;

  localparam cyc_flags_t FLAGS_IDLE = '{we: 1'b0, rmw: 1'b0, fetch: 1'b0};
endpackage

// File: rtl/bcd_clk_phase.sv
module bcd_clk_phase (
  input  logic clk_i,
  output logic phi1_o,
  output logic phi2_o
);
  assign phi1_o = clk_i;
  assign phi2_o = ~clk_i;
endmodule

// File: rtl/bcd_rdy_cond.sv
module bcd_rdy_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_i,
  input  logic sync_en_i,
  input  logic no_wr_pause_i,
  input  logic cyc_we_i,
  output logic stall_o
);
  logic rdy_q;
  logic rdy_c;
  logic pausable;

  // rising-edge sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b1;
    else         rdy_q <= rdy_i;
  end

  assign rdy_c    = sync_en_i ? rdy_q : rdy_i;
  assign pausable = ~(cyc_we_i & no_wr_pause_i);
  assign stall_o  = ~rdy_c & pausable;
endmodule

// File: rtl/bcd_cycle_reg.sv
module bcd_cycle_reg
  import bcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  cyc_flags_t        flags_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output cyc_flags_t        flags_o
);
  // core domain: falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      flags_o <= FLAGS_IDLE;
    end else if (!hold_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      flags_o <= flags_i;
    end
  end
endmodule

// File: rtl/bcd_drive.sv
module bcd_drive
  import bcd_pkg::*;
(
  input  logic       aec_i,
  input  logic       half_wr_i,
  input  logic       phi2_i,
  input  cyc_flags_t flags_i,
  output logic       addr_oe_o,
  output logic       rw_oe_o,
  output logic       data_oe_o,
  output logic       rw_n_o,
  output logic       ml_n_o,
  output logic       sync_o
);
  logic wr_window;

  assign wr_window = half_wr_i ? phi2_i : 1'b1;
  assign addr_oe_o = aec_i;
  assign rw_oe_o   = aec_i;
  assign data_oe_o = aec_i & flags_i.we & wr_window;
  assign rw_n_o    = ~flags_i.we;
  assign ml_n_o    = ~flags_i.rmw;
  assign sync_o    = flags_i.fetch;
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] core_addr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  input  logic              core_we_i,
  input  logic              core_rmw_i,
  input  logic              core_fetch_i,
  input  logic              rdy_i,
  input  logic              aec_i,
  input  logic              strap_wr_nopause_i,
  input  logic              strap_half_wr_i,
  input  logic              strap_sync_rdy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rw_n_o,
  output logic              rw_oe_o,
  output logic              core_stall_o,
  output logic              ml_n_o,
  output logic              sync_o,
  output logic              phi1_o,
  output logic              phi2_o
);
  cyc_flags_t req_flags;
  cyc_flags_t cyc_flags;
  logic       stall;

  assign req_flags = '{we: core_we_i, rmw: core_rmw_i, fetch: core_fetch_i};

  bcd_clk_phase u_clk (
    .clk_i (clk_i),
    .phi1_o(phi1_o),
    .phi2_o(phi2_o)
  );

  bcd_rdy_cond u_rdy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rdy_i        (rdy_i),
    .sync_en_i    (strap_sync_rdy_i),
    .no_wr_pause_i(strap_wr_nopause_i),
    .cyc_we_i     (cyc_flags.we),
    .stall_o      (stall)
  );

  bcd_cycle_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (stall),
    .addr_i (core_addr_i),
    .wdata_i(core_wdata_i),
    .flags_i(req_flags),
    .addr_o (addr_o),
    .wdata_o(data_o),
    .flags_o(cyc_flags)
  );

  bcd_drive u_drv (
    .aec_i    (aec_i),
    .half_wr_i(strap_half_wr_i),
    .phi2_i   (phi2_o),
    .flags_i  (cyc_flags),
    .addr_oe_o(addr_oe_o),
    .rw_oe_o  (rw_oe_o),
    .data_oe_o(data_oe_o),
    .rw_n_o   (rw_n_o),
    .ml_n_o   (ml_n_o),
    .sync_o   (sync_o)
  );

  assign core_stall_o = stall;
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              aec_i,
  input logic              strap_wr_nopause_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_oe_o,
  input logic              data_oe_o,
  input logic              rw_n_o,
  input logic              rw_oe_o,
  input logic              core_stall_o,
  input logic              phi1_o,
  input logic              phi2_o
);
  a_r1_float_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aec_i |-> (!addr_oe_o && !rw_oe_o && !data_oe_o));

  a_r4_write_no_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_wr_nopause_i && !rw_n_o) |-> !core_stall_o);

  a_r5_data_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !rw_n_o);

  a_r8_phases_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi1_o != phi2_o);

  a_r11_hold_on_stall: assert property (@(negedge clk_i) disable iff (!rst_ni)
    core_stall_o |=> ($stable(addr_o) && $stable(rw_n_o)));
endmodule

bind bus_cycle_ctrl bcd_checker #(.ADDR_W(ADDR_W)) u_bcd_checker (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .aec_i             (aec_i),
  .strap_wr_nopause_i(strap_wr_nopause_i),
  .addr_o            (addr_o),
  .addr_oe_o         (addr_oe_o),
  .data_oe_o         (data_oe_o),
  .rw_n_o            (rw_n_o),
  .rw_oe_o           (rw_oe_o),
  .core_stall_o      (core_stall_o),
  .phi1_o            (phi1_o),
  .phi2_o            (phi2_o)
);

// File: tb/tb_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cycle_ctrl;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic core_we = 0, core_rmw = 0, core_fetch = 0;
  logic rdy = 1, aec = 1;
  logic s_nopause = 1, s_half = 1, s_sync = 1;

  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o;
  logic addr_oe, data_oe, rw_n, rw_oe, stall, ml_n, sync, phi1, phi2;

  always #4 clk = ~clk;

  bus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .core_addr_i(core_addr), .core_wdata_i(core_wdata),
    .core_we_i(core_we), .core_rmw_i(core_rmw), .core_fetch_i(core_fetch),
    .rdy_i(rdy), .aec_i(aec),
    .strap_wr_nopause_i(s_nopause), .strap_half_wr_i(s_half), .strap_sync_rdy_i(s_sync),
    .addr_o(addr_o), .addr_oe_o(addr_oe), .data_o(data_o), .data_oe_o(data_oe),
    .rw_n_o(rw_n), .rw_oe_o(rw_oe), .core_stall_o(stall),
    .ml_n_o(ml_n), .sync_o(sync), .phi1_o(phi1), .phi2_o(phi2)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state
  int m_addr, m_data;
  bit m_we, m_rmw, m_fetch;
  bit m_rq;
  bit m_stall;
  bit m_held;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_stall();
    bit rc;
    rc = s_sync ? m_rq : rdy;
    if (m_we && s_nopause) return 1'b0;
    return !rc;
  endfunction

  task automatic check_phase(bit clk_low);
    string st;
    bit exp_doe;
    m_stall = model_stall();
    chk(m_held ? "R11 addr held" : "R2 addr", int'(addr_o), m_addr);
    chk("R2 data", int'(data_o), m_data);
    chk("R2 rw_n", int'(rw_n), int'(!m_we));
    chk("R1 addr_oe", int'(addr_oe), int'(aec));
    chk("R1 rw_oe", int'(rw_oe), int'(aec));
    exp_doe = aec && m_we && (s_half ? clk_low : 1'b1);
    if (!aec) st = "R1 data_oe";
    else if (s_half) st = "R6 data_oe";
    else st = "R5 data_oe";
    chk(st, int'(data_oe), int'(exp_doe));
    if (s_sync) st = "R9 stall";
    else if (m_we) st = "R4 stall";
    else st = "R3 stall";
    chk(st, int'(stall), int'(m_stall));
    chk("R7 ml_n", int'(ml_n), int'(!m_rmw));
    chk("R7 sync", int'(sync), int'(m_fetch));
    chk("R8 phi2", int'(phi2), int'(!clk_low ? 1'b0 : 1'b1));
    chk("R8 phi1", int'(phi1), int'(clk_low ? 1'b0 : 1'b1));
  endtask

  task automatic randomize_inputs();
    core_addr  = AW'($urandom);
    core_wdata = DW'($urandom);
    core_we    = ($urandom % 3) == 0;
    core_rmw   = ($urandom % 4) == 0;
    core_fetch = ($urandom % 3) == 0;
    rdy        = ($urandom % 10) >= 3;
    aec        = ($urandom % 5) != 0;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R10: reset state, with a non-idle request and low wait at the inputs
    core_addr = 16'hBEEF; core_wdata = 8'h5A; core_we = 1; core_rmw = 1; core_fetch = 1;
    rdy = 0; aec = 1; s_sync = 1; s_nopause = 0; s_half = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 addr", int'(addr_o), 0);
    chk("R10 rw_n", int'(rw_n), 1);
    chk("R10 ml_n", int'(ml_n), 1);
    chk("R10 sync", int'(sync), 0);
    chk("R10 data", int'(data_o), 0);
    chk("R10 stall sampled rdy", int'(stall), 0);
    m_addr = 0; m_data = 0; m_we = 0; m_rmw = 0; m_fetch = 0; m_rq = 1; m_held = 0;
    rst_ni = 1;
    #1;
    check_phase(1'b1);
    @(posedge clk); m_rq = rdy; #1; check_phase(1'b0);

    for (int cyc = 0; cyc < 800; cyc++) begin
      @(negedge clk);
      m_held = m_stall;
      if (!m_stall) begin
        m_addr = int'(core_addr); m_data = int'(core_wdata);
        m_we = core_we; m_rmw = core_rmw; m_fetch = core_fetch;
      end
      #1;
      if (cyc % 40 == 0) begin
        s_nopause = $urandom % 2;
        s_half    = $urandom % 2;
        s_sync    = $urandom % 2;
      end
      randomize_inputs();
      #1;
      check_phase(1'b1);
      @(posedge clk);
      m_rq = rdy;
      #1;
      check_phase(1'b0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule